// File: doc/BRIEF.md
# Four-Channel DMA Controller

This block moves data between memory and up to four peripheral devices without the host processor touching each word. The host programs every channel over an 8-bit register port. It sets a starting address, a transfer count and a mode, then unmasks the channel. Work on a channel can start from a device request line or from a software request bit that the host sets.

When an unmasked channel has a request pending, the controller asks for the system bus and waits for a grant. It then runs exactly one transfer: it drives the memory address and a read or write strobe and acknowledges the device, until the memory side signals ready. After the transfer it releases the bus, steps the address and decrements the count.

The transfer in which the count steps from zero to all ones raises terminal count and latches a flag that drives the interrupt. A channel without auto-initialize then masks itself. A channel with auto-initialize reloads its starting values and stays armed.

Top module: `dmac_top`

## Requirements
- R1: After reset all four channels are masked, bus_req, irq and term_cnt are low, the status register (offset 12) reads 0 and the byte pointer selects the low byte.
- R2: Offsets 0..3 hold the address of channel 0..3 and offsets 4..7 hold its count. Each write or read at offsets 0..7 moves one byte, chosen by a byte pointer that starts at the low byte and toggles on every such access. A write at offset 11 returns the pointer to the low byte. A write loads the byte into both the starting and the current value, and a read returns the byte of the current value.
- R3: Mode is written at offset 8 as follows: data[1:0] is the channel and data[2] is the direction, where 0 moves memory to device (mem_rd) and 1 moves device to memory (mem_wr). During a transfer exactly one strobe is high, chan_ack is one-hot on the serviced channel, and mem_addr carries the channel's current address.
- R4: Mode bit data[3] selects the address step. With 0 the address is incremented after each completed transfer, and with 1 it is decremented. The address wraps modulo 2^16.
- R5: The count drops by one per completed transfer, so a count of N gives N+1 transfers. The transfer made with a count of 0 asserts term_cnt while xfer_rdy is high, leaves the count at 0xFFFF and sets the channel's status flag.
- R6: A request seen while the controller is idle raises bus_req on the next cycle. Strobes start only after bus_gnt has been seen and are held with a stable address until xfer_rdy. bus_req drops in the cycle after the transfer completes, so each grant covers one transfer.
- R7: When several unmasked channels have a request pending at the idle sample, the lowest-numbered channel is served first.
- R8: A mask write at offset 10 sets (data[2]=1) or clears (data[2]=0) the mask of channel data[1:0]. A masked channel's device and software requests are ignored. At terminal count a channel without auto-initialize sets its own mask.
- R9: A write at offset 9 sets (data[2]=1) or clears (data[2]=0) the software request of channel data[1:0]. The request starts transfers with no device line asserted and is cleared at terminal count.
- R10: Mode bit data[4] selects auto-initialize. At terminal count such a channel reloads its current address and count from the starting values, and its mask is left unchanged.
- R11: Status at offset 12 reads {software requests[3:0], terminal-count flags[3:0]}, and reading it clears the flags. A flag set in the same cycle as the read survives. irq is the OR of the flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe |
| host_addr | input | 4 | Host register offset |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for the addressed offset |
| chan_req | input | 4 | Device request lines, one per channel |
| chan_ack | output | 4 | Device acknowledge, one-hot during a transfer |
| bus_req | output | 1 | System bus request |
| bus_gnt | input | 1 | System bus grant |
| mem_addr | output | 16 | Memory address during a transfer, 0 otherwise |
| mem_rd | output | 1 | Memory read strobe (memory to device) |
| mem_wr | output | 1 | Memory write strobe (device to memory) |
| xfer_rdy | input | 1 | Memory side completes the current transfer |
| term_cnt | output | 1 | Terminal count, high in the completing cycle |
| irq | output | 1 | Interrupt, high while any terminal-count flag is set |

## Verification
The hardest case to reach from the ports is a status read that lands in exactly the cycle in which a terminal count sets a flag. Only then is it visible that a read-clear must not erase a flag set in the same cycle. The stimulus reaches it with a long software-requested run during which the host reads status back to back, while pseudo-random bus grant and memory ready delays move the terminal-count cycle around. A behavioural reference model follows every cycle, so each coincidence that occurs is compared on irq and on the next status value. Fixed priority, the address wrap below zero and auto-initialize re-arming are each set up by programming two channels at once or by starting a count at its boundary.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 16;

  typedef struct packed {
    logic autoinit;
    logic dec;
    logic to_mem;
  } mode_t;

  typedef enum logic [1:0] {ST_IDLE, ST_BUSREQ, ST_XFER} state_t;

  function automatic logic [15:0] put_byte(input logic [15:0] v, input logic hi,
                                           input logic [7:0] b);
    return hi ? {b, v[7:0]} : {v[15:8], b};
  endfunction

  function automatic logic [7:0] get_byte(input logic [15:0] v, input logic hi);
    return hi ? v[15:8] : v[7:0];
  endfunction

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a,
                                                  input logic dec);
    return dec ? a - ADDR_W'(1) : a + ADDR_W'(1);
  endfunction
endpackage

// File: rtl/dmac_prio.sv
module dmac_prio #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/dmac_chan.sv
module dmac_chan
  import dmac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_addr,
  input  logic              wr_cnt,
  input  logic              ptr_hi,
  input  logic [7:0]        wdata,
  input  logic              wr_mode,
  input  logic              wr_mask,
  input  logic              wr_sreq,
  input  logic              done,
  input  logic              clr_tc,
  input  logic              dreq,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [CNT_W-1:0]  cur_cnt,
  output mode_t             mode,
  output logic              pending,
  output logic              sreq,
  output logic              tc_flag,
  output logic              at_tc
);
  logic [ADDR_W-1:0] base_addr;
  logic [CNT_W-1:0]  base_cnt;
  logic              mask;
  logic              hit_tc;

  assign at_tc   = (cur_cnt == '0);
  assign hit_tc  = done & at_tc;
  assign pending = ~mask & (dreq | sreq);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_addr <= '0;
      base_cnt  <= '0;
      cur_addr  <= '0;
      cur_cnt   <= '0;
      mode      <= '0;
      mask      <= 1'b1;
      sreq      <= 1'b0;
      tc_flag   <= 1'b0;
    end else begin
      if (wr_addr) begin
        base_addr <= put_byte(base_addr, ptr_hi, wdata);
        cur_addr  <= put_byte(cur_addr, ptr_hi, wdata);
      end else if (hit_tc && mode.autoinit) begin
        cur_addr <= base_addr;
      end else if (done) begin
        cur_addr <= step_addr(cur_addr, mode.dec);
      end

      if (wr_cnt) begin
        base_cnt <= put_byte(base_cnt, ptr_hi, wdata);
        cur_cnt  <= put_byte(cur_cnt, ptr_hi, wdata);
      end else if (hit_tc && mode.autoinit) begin
        cur_cnt <= base_cnt;
      end else if (done) begin
        cur_cnt <= cur_cnt - CNT_W'(1);
      end

      if (wr_mode) mode <= mode_t'(wdata[4:2]);

      if (wr_mask) mask <= wdata[2];
      else if (hit_tc && !mode.autoinit) mask <= 1'b1;

      if (wr_sreq) sreq <= wdata[2];
      else if (hit_tc) sreq <= 1'b0;

      if (hit_tc) tc_flag <= 1'b1;
      else if (clr_tc) tc_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/dmac_top.sv
module dmac_top
  import dmac_pkg::*;
#(
  parameter int NCH = 4,
  parameter int HAW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [HAW-1:0]    host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic [NCH-1:0]    chan_req,
  output logic [NCH-1:0]    chan_ack,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  input  logic              xfer_rdy,
  output logic              term_cnt,
  output logic              irq
);
  localparam int CHW = $clog2(NCH);
  localparam logic [HAW-1:0] OFF_CNT  = HAW'(NCH);
  localparam logic [HAW-1:0] OFF_MODE = HAW'(2 * NCH);
  localparam logic [HAW-1:0] OFF_SREQ = HAW'(2 * NCH + 1);
  localparam logic [HAW-1:0] OFF_MASK = HAW'(2 * NCH + 2);
  localparam logic [HAW-1:0] OFF_PTR  = HAW'(2 * NCH + 3);
  localparam logic [HAW-1:0] OFF_STAT = HAW'(2 * NCH + 4);

  state_t            state;
  logic [CHW-1:0]    act_ch;
  logic              ptr_hi;
  logic [NCH-1:0]    pend, at_tc, tc_flag, sreq;
  logic [ADDR_W-1:0] cur_addr [NCH];
  logic [CNT_W-1:0]  cur_cnt  [NCH];
  mode_t             mode     [NCH];
  logic              pick_any;
  logic [CHW-1:0]    pick_idx;
  logic              in_xfer, xfer_done, clr_tc, reg_hit;
  logic [CHW-1:0]    sel_ch;

  assign sel_ch  = host_wdata[CHW-1:0];
  assign clr_tc  = host_rd && (host_addr == OFF_STAT);
  assign reg_hit = (host_wr || host_rd) && (host_addr < OFF_MODE);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dmac_chan u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_addr  (host_wr && host_addr == HAW'(i)),
      .wr_cnt   (host_wr && host_addr == OFF_CNT + HAW'(i)),
      .ptr_hi   (ptr_hi),
      .wdata    (host_wdata),
      .wr_mode  (host_wr && host_addr == OFF_MODE && sel_ch == CHW'(i)),
      .wr_mask  (host_wr && host_addr == OFF_MASK && sel_ch == CHW'(i)),
      .wr_sreq  (host_wr && host_addr == OFF_SREQ && sel_ch == CHW'(i)),
      .done     (xfer_done && act_ch == CHW'(i)),
      .clr_tc   (clr_tc),
      .dreq     (chan_req[i]),
      .cur_addr (cur_addr[i]),
      .cur_cnt  (cur_cnt[i]),
      .mode     (mode[i]),
      .pending  (pend[i]),
      .sreq     (sreq[i]),
      .tc_flag  (tc_flag[i]),
      .at_tc    (at_tc[i])
    );
  end

  dmac_prio #(.N(NCH), .IW(CHW)) u_prio (
    .req (pend),
    .any (pick_any),
    .idx (pick_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      act_ch <= '0;
      ptr_hi <= 1'b0;
    end else begin
      case (state)
        ST_IDLE:   if (pick_any) begin
                     state  <= ST_BUSREQ;
                     act_ch <= pick_idx;
                   end
        ST_BUSREQ: if (bus_gnt) state <= ST_XFER;
        ST_XFER:   if (xfer_rdy) state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
      if (host_wr && host_addr == OFF_PTR) ptr_hi <= 1'b0;
      else if (reg_hit) ptr_hi <= ~ptr_hi;
    end
  end

  assign in_xfer   = (state == ST_XFER);
  assign xfer_done = in_xfer && xfer_rdy;
  assign bus_req   = (state != ST_IDLE);
  assign mem_addr  = in_xfer ? cur_addr[act_ch] : '0;
  assign mem_rd    = in_xfer && !mode[act_ch].to_mem;
  assign mem_wr    = in_xfer && mode[act_ch].to_mem;
  assign chan_ack  = in_xfer ? (NCH'(1) << act_ch) : '0;
  assign term_cnt  = xfer_done && at_tc[act_ch];
  assign irq       = |tc_flag;

  always_comb begin
    host_rdata = '0;
    if (host_addr < OFF_CNT)
      host_rdata = get_byte(cur_addr[host_addr[CHW-1:0]], ptr_hi);
    else if (host_addr < OFF_MODE)
      host_rdata = get_byte(cur_cnt[host_addr[CHW-1:0]], ptr_hi);
    else if (host_addr == OFF_STAT)
      host_rdata = 8'({sreq, tc_flag});
  end
endmodule

// File: rtl/dmac_chk.sv
module dmac_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_req,
  input logic           bus_gnt,
  input logic           mem_rd,
  input logic           mem_wr,
  input logic [15:0]    mem_addr,
  input logic [NCH-1:0] chan_ack,
  input logic           xfer_rdy,
  input logic           xfer_done,
  input logic           term_cnt,
  input logic           irq
);
  logic strobe;
  assign strobe = mem_rd || mem_wr;

  assert_rd_wr_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  assert_ack_with_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe == (chan_ack != '0));

  assert_single_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_ack));

  assert_strobe_after_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe) |-> $past(bus_gnt) && bus_req);

  assert_strobe_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && !xfer_rdy |=> strobe && $stable(mem_addr));

  assert_release_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !bus_req);

  assert_tc_only_on_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    term_cnt |-> xfer_done);

  assert_irq_after_tc_R11: assert property (@(posedge clk) disable iff (!rst_n)
    term_cnt |=> irq);
endmodule

bind dmac_top dmac_chk #(.NCH(NCH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_req   (bus_req),
  .bus_gnt   (bus_gnt),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .mem_addr  (mem_addr),
  .chan_ack  (chan_ack),
  .xfer_rdy  (xfer_rdy),
  .xfer_done (xfer_done),
  .term_cnt  (term_cnt),
  .irq       (irq)
);

// File: tb/dmac_top_tb_top.sv
`timescale 1ns/1ps
module dmac_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_wr = 1'b0, host_rd = 1'b0;
  logic [3:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic [3:0] chan_req = '0;
  logic [3:0] chan_ack;
  logic bus_req, bus_gnt = 1'b0, mem_rd, mem_wr, xfer_rdy = 1'b0, term_cnt, irq;
  logic [15:0] mem_addr;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  dmac_top dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .chan_req(chan_req), .chan_ack(chan_ack), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .xfer_rdy(xfer_rdy),
    .term_cnt(term_cnt), .irq(irq)
  );

  // ---------------- reference model ----------------
  int m_ba[4], m_bc[4], m_ca[4], m_cc[4];
  bit m_dir[4], m_dec[4], m_ai[4], m_mask[4], m_sreq[4], m_tcf[4];
  bit m_ptr;
  int m_phase, m_ch;

  function automatic int putb(int v, bit hi, int d);
    if (hi) return (v % 256) + d * 256;
    return (v / 256) * 256 + d;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin
      m_ba[i] = 0; m_bc[i] = 0; m_ca[i] = 0; m_cc[i] = 0;
      m_dir[i] = 0; m_dec[i] = 0; m_ai[i] = 0;
      m_mask[i] = 1; m_sreq[i] = 0; m_tcf[i] = 0;
    end
    m_ptr = 0; m_phase = 0; m_ch = 0;
  endtask

  task automatic model_step();
    int sel, c, a, d;
    sel = -1;
    for (int i = 3; i >= 0; i--)
      if (!m_mask[i] && (chan_req[i] || m_sreq[i])) sel = i;
    if (host_rd && host_addr == 12)
      for (int i = 0; i < 4; i++) m_tcf[i] = 0;
    if (m_phase == 2 && xfer_rdy) begin
      c = m_ch;
      if (m_cc[c] == 0) begin
        m_tcf[c] = 1; m_sreq[c] = 0;
        if (m_ai[c]) begin
          m_ca[c] = m_ba[c]; m_cc[c] = m_bc[c];
        end else begin
          m_mask[c] = 1; m_cc[c] = 65535;
          m_ca[c] = (m_ca[c] + (m_dec[c] ? 65535 : 1)) % 65536;
        end
      end else begin
        m_cc[c] = m_cc[c] - 1;
        m_ca[c] = (m_ca[c] + (m_dec[c] ? 65535 : 1)) % 65536;
      end
    end
    case (m_phase)
      0: if (sel >= 0) begin m_phase = 1; m_ch = sel; end
      1: if (bus_gnt) m_phase = 2;
      2: if (xfer_rdy) m_phase = 0;
      default: m_phase = 0;
    endcase
    if (host_wr) begin
      a = host_addr; d = host_wdata;
      if (a < 4) begin
        m_ba[a] = putb(m_ba[a], m_ptr, d); m_ca[a] = putb(m_ca[a], m_ptr, d);
      end else if (a < 8) begin
        m_bc[a-4] = putb(m_bc[a-4], m_ptr, d); m_cc[a-4] = putb(m_cc[a-4], m_ptr, d);
      end else if (a == 8) begin
        m_dir[d % 4] = (d / 4) % 2; m_dec[d % 4] = (d / 8) % 2; m_ai[d % 4] = (d / 16) % 2;
      end else if (a == 9) m_sreq[d % 4] = (d / 4) % 2;
      else if (a == 10) m_mask[d % 4] = (d / 4) % 2;
    end
    if (host_wr && host_addr == 11) m_ptr = 0;
    else if ((host_wr || host_rd) && host_addr < 8) m_ptr = !m_ptr;
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else model_step();
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    int e_addr, e_ack, e_rd, e_wr, e_tc, e_irq, e_rdata, a, v;
    #1;
    if (rst_n && !finished) begin
      e_rd = (m_phase == 2) && !m_dir[m_ch];
      e_wr = (m_phase == 2) && m_dir[m_ch];
      e_addr = (m_phase == 2) ? m_ca[m_ch] : 0;
      e_ack = (m_phase == 2) ? (1 << m_ch) : 0;
      e_tc = (m_phase == 2) && xfer_rdy && (m_cc[m_ch] == 0);
      e_irq = m_tcf[0] | m_tcf[1] | m_tcf[2] | m_tcf[3];
      chk("R6 bus_req", bus_req, m_phase != 0);
      chk("R3 mem_rd", mem_rd, e_rd);
      chk("R3 mem_wr", mem_wr, e_wr);
      chk("R4 mem_addr", mem_addr, e_addr);
      chk("R7 chan_ack", chan_ack, e_ack);
      chk("R5 term_cnt", term_cnt, e_tc);
      chk("R11 irq", irq, e_irq);
      if (host_rd) begin
        a = host_addr; e_rdata = 0;
        if (a < 8) begin
          v = (a < 4) ? m_ca[a] : m_cc[a-4];
          e_rdata = m_ptr ? v / 256 : v % 256;
        end else if (a == 12) begin
          for (int i = 0; i < 4; i++) e_rdata += (m_tcf[i] << i) + (m_sreq[i] << (i + 4));
        end
        chk("R2 host_rdata", host_rdata, e_rdata);
      end
    end
  end

  // bus and memory responders with pseudo-random delays
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    bus_gnt <= bus_req && lfsr[0];
    xfer_rdy <= (mem_rd || mem_wr) && lfsr[3];
  end

  task automatic host_write(input int a, input int d);
    @(negedge clk); host_wr = 1'b1; host_addr = a[3:0]; host_wdata = d[7:0];
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic host_read(input int a, output int d);
    @(negedge clk); host_rd = 1'b1; host_addr = a[3:0];
    #1 d = host_rdata;
    @(negedge clk); host_rd = 1'b0;
  endtask

  task automatic wait_irq(input string tag);
    int n;
    n = 0;
    while (irq !== 1'b1 && n < 2000) begin @(negedge clk); #1; n++; end
    chk(tag, irq, 1);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int d, lo, hi, first, saw;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk("R1 bus_req after reset", bus_req, 0);
    chk("R1 irq after reset", irq, 0);
    host_read(12, d); chk("R1 status after reset", d, 0);

    // R3 R4 R5 R8: ch2 device-driven, device to memory, increment, 3 transfers
    host_write(2, 8'h34); host_write(2, 8'h12);
    host_write(6, 8'h02); host_write(6, 8'h00);
    host_write(8, 8'h06);
    host_write(10, 8'h02);
    @(negedge clk); chan_req[2] = 1'b1;
    wait_irq("R5 irq after ch2 run");
    @(negedge clk); chan_req[2] = 1'b0;
    host_read(12, d); chk("R11 status shows ch2 tc", d, 8'h04);
    host_read(12, d); chk("R11 status cleared by read", d, 0);
    host_read(2, lo); host_read(2, hi); chk("R4 ch2 address stepped up", hi * 256 + lo, 16'h1237);
    host_read(6, lo); host_read(6, hi); chk("R5 ch2 count wrapped", hi * 256 + lo, 16'hFFFF);
    // R8: ch2 masked itself; requests ignored
    @(negedge clk); chan_req[2] = 1'b1; saw = 0;
    repeat (30) begin @(negedge clk); #1; if (bus_req) saw = 1; end
    chan_req[2] = 1'b0;
    chk("R8 masked channel ignored", saw, 0);

    // R9 R4: ch1 software request, memory to device, decrement through zero
    host_write(1, 8'h01); host_write(1, 8'h00);
    host_write(5, 8'h01); host_write(5, 8'h00);
    host_write(8, 8'h09);
    host_write(10, 8'h01);
    host_write(9, 8'h05);
    wait_irq("R9 irq after software run");
    idle(3);
    host_read(12, d); chk("R9 request cleared at tc", d, 8'h02);
    host_read(1, lo); host_read(1, hi); chk("R4 ch1 address wrapped down", hi * 256 + lo, 16'hFFFF);

    // R7: ch0 and ch3 together
    host_write(0, 8'h00); host_write(0, 8'h01);
    host_write(4, 8'h01); host_write(4, 8'h00);
    host_write(3, 8'h00); host_write(3, 8'h03);
    host_write(7, 8'h01); host_write(7, 8'h00);
    host_write(8, 8'h04); host_write(8, 8'h07);
    host_write(10, 8'h00); host_write(10, 8'h03);
    @(negedge clk); chan_req[0] = 1'b1; chan_req[3] = 1'b1; first = 0;
    for (int n = 0; n < 200; n++) begin @(negedge clk); #1; if (chan_ack != 0) begin first = chan_ack; break; end end
    chk("R7 lowest channel first", first, 1);
    idle(150);
    chan_req = '0;
    host_read(12, d); chk("R5 both channels reached tc", d, 8'h09);

    // R10: ch0 auto-initialize, one transfer per run
    host_write(0, 8'h40); host_write(0, 8'h00);
    host_write(4, 8'h00); host_write(4, 8'h00);
    host_write(8, 8'h10);
    host_write(10, 8'h00);
    host_write(9, 8'h04);
    wait_irq("R10 irq after auto-init run");
    idle(3);
    host_read(12, d); chk("R10 tc flag and request cleared", d, 8'h01);
    host_read(0, lo); host_read(0, hi); chk("R10 address reloaded", hi * 256 + lo, 16'h0040);
    @(negedge clk); chan_req[0] = 1'b1; saw = 0;
    repeat (30) begin @(negedge clk); #1; if (bus_req) saw = 1; end
    chan_req[0] = 1'b0;
    chk("R10 channel stays armed", saw, 1);
    idle(40);
    host_read(12, d);

    // R2: pointer clear
    host_write(3, 8'hAA); host_write(11, 8'h00);
    host_write(3, 8'h55); host_write(3, 8'h66);
    host_read(3, lo); host_read(3, hi); chk("R2 pointer cleared before low byte", hi * 256 + lo, 16'h6655);

    // R11: status polling racing terminal count
    host_write(6, 8'h06); host_write(6, 8'h00);
    host_write(10, 8'h02);
    host_write(9, 8'h06);
    for (int n = 0; n < 60; n++) host_read(12, d);
    idle(200);
    host_read(12, d);
    @(negedge clk); #1;
    chk("R11 irq low after final read", irq, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule